// File: doc/BRIEF.md
# UART Interrupt Mask and Status Unit

This block collects the event sources of a UART (receive trigger, receive empty and full, transmit empty and full, overrun, framing, parity and receive timeout) into a sticky latched status register. It gates each event with a mask bit and drives one interrupt request line. The mask has no read-write port. Software sets mask bits through a write-one enable port and clears them through a write-one disable port, and it reads the result back through a read-only mask view.

Latched status bits stay set until software writes a one to them. A separate channel view bypasses both the mask and the latch. It shows the live levels of the four FIFO conditions, so software can poll them while their interrupts are masked. The event generators and the bus protocol sit outside this block. The block sees per-cycle event inputs and plain write-data ports, where a zero bit means no action.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask and the latched status are all zero and the interrupt line is low.
- R2: A 1 on a bit of the enable port sets that mask bit at the next clock edge. A 0 leaves the bit unchanged.
- R3: A 1 on a bit of the disable port clears that mask bit at the next clock edge. A 0 leaves the bit unchanged.
- R4: When the enable and disable ports both carry 1 on the same bit in the same cycle, that mask bit ends up cleared.
- R5: An event input sets its status bit at the next edge only if its mask bit is set in that cycle. The event bits are: 0 RX trigger, 1 RX empty, 2 RX full, 3 TX empty, 4 TX full, 5 overrun, 6 framing, 7 parity, 8 RX timeout.
- R6: A status bit stays set until a 1 is written to it on the clear port. Writing 0 to the clear port leaves the bit unchanged.
- R7: When a masked-in event arrives in the same cycle as a clear of its bit, the bit stays set.
- R8: The interrupt line is high exactly when some status bit and its mask bit are both set. Clearing a mask bit therefore drops the line even though the status bit is still held.
- R9: The channel view shows the live event inputs on bits 0, 1, 3 and 4 whatever the mask holds, and reads zero on the other bits.
- R10: The read-back ports of the enable and disable registers always read zero.
- R11: The mask view always shows the current mask register, including bits that nothing has set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_set_i | input | 9 | Write-one-to-set data for the mask |
| dis_clr_i | input | 9 | Write-one-to-clear data for the mask |
| sts_w1c_i | input | 9 | Write-one-to-clear data for the latched status |
| evt_i | input | 9 | Event pulses and level conditions, one bit per source |
| mask_o | output | 9 | Read-only mask view |
| status_o | output | 9 | Latched interrupt status |
| chan_o | output | 9 | Live channel view of the FIFO conditions |
| en_rd_o | output | 9 | Read-back of the enable port, always zero |
| dis_rd_o | output | 9 | Read-back of the disable port, always zero |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the write-data ports are zero except in the cycles software writes them. They also assume that an event input is either a one-cycle pulse or a level held by its generator, and they place no other limit on when events arrive. The stimulus keeps to this by driving enable, disable and clear values only in short sparse bursts, with all other cycles at zero. Event inputs carry both single-cycle pulses and held levels. Directed cycles line up the boundary cases: both mask ports hitting one bit, a clear landing on an arriving event, and a mask being dropped under a pending status.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int EVT_W = 9;

  localparam int EV_RX_TRIG  = 0;
  localparam int EV_RX_EMPTY = 1;
  localparam int EV_RX_FULL  = 2;
  localparam int EV_TX_EMPTY = 3;
  localparam int EV_TX_FULL  = 4;
  localparam int EV_OVERRUN  = 5;
  localparam int EV_FRAMING  = 6;
  localparam int EV_PARITY   = 7;
  localparam int EV_RX_TOUT  = 8;

  // Sources that the live channel view passes through unmasked.
  localparam logic [EVT_W-1:0] LIVE_SEL =
      (EVT_W'(1) << EV_RX_TRIG)  | (EVT_W'(1) << EV_RX_EMPTY) |
      (EVT_W'(1) << EV_TX_EMPTY) | (EVT_W'(1) << EV_TX_FULL);

  // One mask bit: disable wins over enable, zeros hold.
  function automatic logic mask_bit_next(input logic cur, input logic set,
                                         input logic clr);
    return (cur | set) & ~clr;
  endfunction

  // One sticky status bit: a gated event wins over a clear.
  function automatic logic sts_bit_next(input logic cur, input logic hit,
                                        input logic clr);
    return hit | (cur & ~clr);
  endfunction

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = uart_irq_pkg::EVT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mask_o
);
  import uart_irq_pkg::*;

  logic [W-1:0] mask_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[b] <= 1'b0;
      else        mask_q[b] <= mask_bit_next(mask_q[b], set_i[b], clr_i[b]);
    end
  end

  assign mask_o = mask_q;

  AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i))); // R2
  AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_q & $past(clr_i)) == '0)); // R4
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((mask_q ^ $past(mask_q)) & ~$past(set_i | clr_i)) == '0)); // R3

endmodule

// File: rtl/irq_sticky_sts.sv
module irq_sticky_sts #(
  parameter int W = uart_irq_pkg::EVT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] w1c_i,
  output logic [W-1:0] sts_o
);
  import uart_irq_pkg::*;

  logic [W-1:0] sts_q;
  logic [W-1:0] gated_hit;   // events allowed through the mask this cycle

  assign gated_hit = evt_i & mask_i;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[b] <= 1'b0;
      else        sts_q[b] <= sts_bit_next(sts_q[b], gated_hit[b], w1c_i[b]);
    end
  end

  assign sts_o = sts_q;

  AST_STS_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((sts_q & ~$past(sts_q)) & ~$past(evt_i & mask_i)) == '0)); // R5
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sts_q) & ~$past(w1c_i)) & ~sts_q) == '0)); // R6
  AST_STS_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(evt_i & mask_i)) == $past(evt_i & mask_i))); // R7

endmodule

// File: rtl/irq_live_view.sv
module irq_live_view #(
  parameter int           W    = uart_irq_pkg::EVT_W,
  parameter logic [W-1:0] LIVE = uart_irq_pkg::LIVE_SEL
) (
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] view_o
);
  assign view_o = evt_i & LIVE;

  always_comb begin
    AST_LIVE_NO_EXTRA: assert ((view_o & ~LIVE) == '0); // R9
  end

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int W = uart_irq_pkg::EVT_W
) (
  input  logic [W-1:0] sts_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic [W-1:0] armed;

  for (genvar b = 0; b < W; b++) begin : g_arm
    assign armed[b] = sts_i[b] & mask_i[b];
  end

  assign irq_o = |armed;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int           W        = uart_irq_pkg::EVT_W,
  parameter logic [W-1:0] LIVE_SEL = uart_irq_pkg::LIVE_SEL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] en_set_i,
  input  logic [W-1:0] dis_clr_i,
  input  logic [W-1:0] sts_w1c_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] status_o,
  output logic [W-1:0] chan_o,
  output logic [W-1:0] en_rd_o,
  output logic [W-1:0] dis_rd_o,
  output logic         irq_o
);
  logic [W-1:0] mask_w;
  logic [W-1:0] sts_w;
  logic         irq_w;

  irq_mask_reg #(.W(W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_i(en_set_i), .clr_i(dis_clr_i),
    .mask_o(mask_w)
  );

  irq_sticky_sts #(.W(W)) u_sts (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_i(mask_w),
    .w1c_i(sts_w1c_i), .sts_o(sts_w)
  );

  irq_live_view #(.W(W), .LIVE(LIVE_SEL)) u_live (
    .evt_i(evt_i), .view_o(chan_o)
  );

  irq_req_gen #(.W(W)) u_irq (
    .sts_i(sts_w), .mask_i(mask_w), .irq_o(irq_w)
  );

  assign mask_o   = mask_w;
  assign status_o = sts_w;
  assign irq_o    = irq_w;
  assign en_rd_o  = '0;   // write-only port
  assign dis_rd_o = '0;   // write-only port

  AST_IRQ_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_w |-> ((sts_w & mask_w) != '0)); // R8
  AST_IRQ_WHEN_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_w & mask_w) != '0) |-> irq_w); // R8
  AST_RESET_CLEAN: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_w == '0 && sts_w == '0)); // R1

endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;

  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] en_set = '0, dis_clr = '0, w1c = '0, evt = '0;
  logic [W-1:0] mask_o, status_o, chan_o, en_rd_o, dis_rd_o;
  logic         irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  uart_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .en_set_i(en_set), .dis_clr_i(dis_clr),
    .sts_w1c_i(w1c), .evt_i(evt), .mask_o(mask_o), .status_o(status_o),
    .chan_o(chan_o), .en_rd_o(en_rd_o), .dis_rd_o(dis_rd_o), .irq_o(irq_o)
  );

  // Behavioural reference model
  bit ref_mask [W];
  bit ref_sts  [W];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < W; i++) begin ref_mask[i] <= 0; ref_sts[i] <= 0; end
    end else begin
      for (int i = 0; i < W; i++) begin
        if (evt[i] && ref_mask[i]) ref_sts[i] <= 1;
        else if (w1c[i])           ref_sts[i] <= 0;
        if (dis_clr[i])            ref_mask[i] <= 0;
        else if (en_set[i])        ref_mask[i] <= 1;
      end
    end
  end

  function automatic int pack_bits(input bit a [W]);
    int v = 0;
    for (int i = 0; i < W; i++) if (a[i]) v += (1 << i);
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int exp_mask, exp_sts, exp_chan, exp_irq;
    exp_mask = pack_bits(ref_mask);
    exp_sts  = pack_bits(ref_sts);
    exp_irq  = 0;
    for (int i = 0; i < W; i++) if (ref_mask[i] && ref_sts[i]) exp_irq = 1;
    exp_chan = 0;
    foreach (evt[i]) if (evt[i] && (i == 0 || i == 1 || i == 3 || i == 4))
      exp_chan += (1 << i);
    check({tag, " mask R2 R3 R4 R11"}, int'(mask_o), exp_mask);
    check({tag, " status R5 R6 R7"}, int'(status_o), exp_sts);
    check({tag, " irq R8"}, int'(irq_o), exp_irq);
    check({tag, " chan R9"}, int'(chan_o), exp_chan);
    check({tag, " readback R10"}, int'(en_rd_o | dis_rd_o), 0);
  endtask

  // drive at a falling edge, let one rising edge pass, compare at the next fall
  task automatic cyc(input string tag, input logic [W-1:0] e, input logic [W-1:0] d,
                     input logic [W-1:0] c, input logic [W-1:0] v);
    en_set = e; dis_clr = d; w1c = c; evt = v;
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #400000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // reset with busy inputs
    evt = '1; en_set = '1; w1c = '0;
    repeat (3) @(negedge clk);
    en_set = '0; evt = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mask after reset", int'(mask_o), 0);
    check("R1 status after reset", int'(status_o), 0);
    check("R1 irq after reset", int'(irq_o), 0);

    // R5: event while masked does nothing
    cyc("R5 masked event", 9'h000, 9'h000, 9'h000, 9'h1FF);
    check("R5 no latch when masked", int'(status_o), 0);
    // R2: enable two bits
    cyc("R2 enable", 9'h0A1, 9'h000, 9'h000, 9'h000);
    check("R2 mask set", int'(mask_o), 'h0A1);
    // R2: zero write keeps
    cyc("R2 zero enable", 9'h000, 9'h000, 9'h000, 9'h000);
    // R5: parity event (bit 7) latched
    cyc("R5 parity event", 9'h000, 9'h000, 9'h000, 9'h080);
    check("R5 parity latched", int'(status_o), 'h080);
    check("R8 irq up", int'(irq_o), 1);
    // R6: clear with zero -> stays
    cyc("R6 zero clear", 9'h000, 9'h000, 9'h000, 9'h000);
    check("R6 sticky", int'(status_o), 'h080);
    // R7: clear and event together
    cyc("R7 clear vs event", 9'h000, 9'h000, 9'h080, 9'h080);
    check("R7 event wins", int'(status_o), 'h080);
    // R8: disable mask drops irq, status held
    cyc("R8 mask off", 9'h000, 9'h080, 9'h000, 9'h000);
    check("R8 irq down", int'(irq_o), 0);
    check("R8 status held", int'(status_o), 'h080);
    // R6: real clear
    cyc("R6 clear", 9'h000, 9'h000, 9'h080, 9'h000);
    check("R6 cleared", int'(status_o), 0);
    // R4: enable and disable together
    cyc("R4 both", 9'h100, 9'h100, 9'h000, 9'h000);
    check("R4 bit8 cleared", int'(mask_o) & 'h100, 0);
    cyc("R4 both on set bit", 9'h001, 9'h001, 9'h000, 9'h000);
    check("R4 bit0 cleared", int'(mask_o) & 'h001, 0);
    // R3: disable zero leaves others
    cyc("R3 disable bit5", 9'h000, 9'h020, 9'h000, 9'h000);
    check("R3 bit5 gone", int'(mask_o), 0);
    // R9: live view with everything masked
    cyc("R9 live", 9'h000, 9'h000, 9'h000, 9'h1FF);
    check("R9 live bits", int'(chan_o), 'h01B);

    // mixed patterns: levels and pulses with sparse writes
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] e, d, c, v;
      e = ($urandom % 4 == 0) ? W'($urandom) : '0;
      d = ($urandom % 5 == 0) ? W'($urandom) : '0;
      c = ($urandom % 3 == 0) ? W'($urandom) : '0;
      v = (k % 50 < 25) ? (W'($urandom) & 9'h0E4) | 9'h01B : W'($urandom);
      cyc("random", e, d, c, v);
    end

    en_set = '0; dis_clr = '0; w1c = '0; evt = '0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule